// File: doc/BRIEF.md
# Latching Threshold Alert Controller

This block watches a stream of completed conversion results and raises an active-low alert whenever a result leaves a programmable band. Each result arrives with a one-cycle valid strobe. The block compares it against an upper limit and a lower limit. In window mode, a result above the upper limit or below the lower limit raises the alert. In traditional mode, only a result above the upper limit raises it, and the alert drops again only when a result falls below the lower limit. The output works like an open-drain pin: it is pulled low while the alert is active and released high at all other times.

With latching turned on, an alert stays raised until one of two clear events is seen. The first is a read of the conversion result. The second is an alert-response transaction that this device won. A lost response clears nothing. A status bit records the direction of the most recent excursion, so the serial front end can return it during the alert response. The block has no part in starting or timing conversions: asserting or clearing the alert only changes the alert state.

Top module: `thr_alert_ctrl`

## Requirements
- R1: After reset, `alert_n` is 1, `alert_pull` is 0 and `alert_status` is 0.
- R2: Comparisons are signed two's-complement. An excursion is a result strictly greater than `thresh_hi` or strictly less than `thresh_lo`. A result equal to either limit is not an excursion.
- R3: In window mode (`window_mode`=1), a valid result that is an excursion in either direction drives `alert_n` low on the cycle after the strobe.
- R4: In traditional mode (`window_mode`=0), only a result above `thresh_hi` raises the alert. Without latching, the alert drops only on a result below `thresh_lo` and holds for results inside the band.
- R5: With `latch_en`=1, a raised alert stays raised after later results return inside the limits.
- R6: With `latch_en`=1, a `data_read` pulse clears a latched alert on the next cycle.
- R7: With `latch_en`=1, a `resp_done` pulse with `resp_won`=1 clears the alert. A `resp_done` pulse with `resp_won`=0 leaves it raised.
- R8: After a clear, a later out-of-range result raises the alert again.
- R9: If a clear event and an alert-raising result arrive in the same cycle, the alert stays raised.
- R10: `alert_status` is set to 1 by an excursion above `thresh_hi`. In window mode it is set to 0 by an excursion below `thresh_lo`. In traditional mode a low excursion leaves it unchanged, and it holds its value whenever no excursion occurs. If both excursions happen at once, 1 wins.
- R11: With `latch_en`=0, `data_read` and `resp_done` have no effect, and in window mode the alert follows each new result.
- R12: With `alert_en`=0, the output is released (`alert_n`=1, `alert_pull`=0), the alert state is cleared, and results are ignored, including for `alert_status`. `alert_pull` is always the inverse of `alert_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alert_en | input | 1 | Alert function enable |
| latch_en | input | 1 | 1 = alert latches until cleared |
| window_mode | input | 1 | 1 = window comparator, 0 = traditional |
| thresh_hi | input | 16 | Upper limit, signed |
| thresh_lo | input | 16 | Lower limit, signed |
| conv_valid | input | 1 | One-cycle strobe for a completed result |
| conv_result | input | 16 | Conversion result, signed |
| data_read | input | 1 | Pulse: conversion result was read |
| resp_done | input | 1 | Pulse: alert-response address phase finished |
| resp_won | input | 1 | Qualifies `resp_done`: arbitration was won |
| alert_n | output | 1 | Alert level, low when active |
| alert_pull | output | 1 | Open-drain pull-down enable |
| alert_status | output | 1 | Direction of the last recorded excursion |

## Verification
The assertions assume that `conv_valid`, `data_read` and `resp_done` are single-cycle pulses that are synchronous to `clk`. They also assume that `resp_won` is meaningful only while `resp_done` is high, and that the limits and mode bits are stable around a strobe. The stimulus changes configuration only between transactions, on the falling edge, and raises each strobe for exactly one cycle. It also drives a clear and an alert-raising result together on purpose, so the same-cycle priority is exercised.

// File: rtl/thr_alert_pkg.sv
package thr_alert_pkg;

   // Result of comparing one conversion against both limits
   typedef struct packed {
      logic above;  // result > upper limit
      logic below;  // result < lower limit
   } thr_cmp_t;

   // Operating mode derived from the configuration inputs
   typedef enum logic [1:0] {
      MODE_TRAD_FOLLOW  = 2'b00,
      MODE_WIN_FOLLOW   = 2'b01,
      MODE_TRAD_LATCH   = 2'b10,
      MODE_WIN_LATCH    = 2'b11
   } thr_mode_e;

endpackage

// File: rtl/thr_alert_cmp.sv
module thr_alert_cmp
   import thr_alert_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] lim_hi,
   input  logic [DATA_W-1:0] lim_lo,
   output thr_cmp_t          cmp
);

   localparam int MIN_W = 2;

   generate
      if (DATA_W < MIN_W) begin : g_bad_width
         $error("thr_alert_cmp: DATA_W must be at least %0d", MIN_W);
      end

      if (SIGNED_CMP) begin : g_signed
         always_comb begin
            cmp.above = $signed(value) > $signed(lim_hi);
            cmp.below = $signed(value) < $signed(lim_lo);
         end
      end else begin : g_unsigned
         always_comb begin
            cmp.above = value > lim_hi;
            cmp.below = value < lim_lo;
         end
      end
   endgenerate

endmodule

// File: rtl/thr_alert_core.sv
module thr_alert_core
   import thr_alert_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     latch,
   input  logic     win,
   input  logic     valid,
   input  thr_cmp_t cmp,
   input  logic     rd_clr,
   input  logic     rsp_done,
   input  logic     rsp_won,
   output logic     alert_q,
   output logic     dir_q
);

   thr_mode_e mode;
   logic      raise;
   logic      drop_trad;
   logic      clr_evt;
   logic      alert_d;
   logic      dir_d;

   always_comb begin
      mode      = thr_mode_e'({latch, win});
      raise     = valid & (cmp.above | (win & cmp.below));
      drop_trad = valid & cmp.below & ~cmp.above;
      clr_evt   = rd_clr | (rsp_done & rsp_won);
   end

   always_comb begin
      alert_d = alert_q;
      if (!en) begin
         alert_d = 1'b0;
      end else begin
         unique case (mode)
            MODE_WIN_LATCH,
            MODE_TRAD_LATCH: begin
               if (raise)        alert_d = 1'b1;
               else if (clr_evt) alert_d = 1'b0;
            end
            MODE_WIN_FOLLOW: begin
               if (valid) alert_d = raise;
            end
            MODE_TRAD_FOLLOW: begin
               if (raise)          alert_d = 1'b1;
               else if (drop_trad) alert_d = 1'b0;
            end
            default: alert_d = alert_q;
         endcase
      end
   end

   always_comb begin
      dir_d = dir_q;
      if (en && valid) begin
         if (cmp.above)            dir_d = 1'b1;
         else if (win && cmp.below) dir_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alert_q <= 1'b0;
         dir_q   <= 1'b0;
      end else begin
         alert_q <= alert_d;
         dir_q   <= dir_d;
      end
   end

   // Latched alert survives an in-range result when no clear arrives
   assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      en && latch && alert_q && !rd_clr && !rsp_done |=> alert_q);

   // Read of the result clears a latched alert
   assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      en && latch && rd_clr && !valid |=> !alert_q);

   // Lost response leaves the alert raised
   assert_lost_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en && latch && alert_q && rsp_done && !rsp_won && !rd_clr |=> alert_q);

   // Same-cycle clear and excursion keeps alert raised
   assert_clear_race_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en && latch && valid && cmp.above && (rd_clr || rsp_done) |=> alert_q);

   // Window mode records direction of excursion
   assert_dir_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
      en && valid && cmp.above |=> dir_q);
   assert_dir_lower_R10: assert property (@(posedge clk) disable iff (!rst_n)
      en && valid && win && cmp.below && !cmp.above |=> !dir_q);

   // Non-latching: clears alone change nothing
   assert_follow_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      en && !latch && !valid |=> $stable(alert_q));

   // Disabled: state cleared, direction untouched
   assert_disable_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !alert_q && $stable(dir_q));

endmodule

// File: rtl/thr_alert_pad.sv
module thr_alert_pad (
   input  logic active,
   input  logic en,
   output logic pull,
   output logic level_n
);

   always_comb begin
      pull    = active & en;
      level_n = ~pull;
   end

endmodule

// File: rtl/thr_alert_ctrl.sv
module thr_alert_ctrl
   import thr_alert_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alert_en,
   input  logic              latch_en,
   input  logic              window_mode,
   input  logic [DATA_W-1:0] thresh_hi,
   input  logic [DATA_W-1:0] thresh_lo,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_result,
   input  logic              data_read,
   input  logic              resp_done,
   input  logic              resp_won,
   output logic              alert_n,
   output logic              alert_pull,
   output logic              alert_status
);

   thr_cmp_t cmp;
   logic     alert_q;
   logic     dir_q;

   thr_alert_cmp #(
      .DATA_W     (DATA_W),
      .SIGNED_CMP (SIGNED_CMP)
   ) u_cmp (
      .value  (conv_result),
      .lim_hi (thresh_hi),
      .lim_lo (thresh_lo),
      .cmp    (cmp)
   );

   thr_alert_core u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (alert_en),
      .latch    (latch_en),
      .win      (window_mode),
      .valid    (conv_valid),
      .cmp      (cmp),
      .rd_clr   (data_read),
      .rsp_done (resp_done),
      .rsp_won  (resp_won),
      .alert_q  (alert_q),
      .dir_q    (dir_q)
   );

   thr_alert_pad u_pad (
      .active  (alert_q),
      .en      (alert_en),
      .pull    (alert_pull),
      .level_n (alert_n)
   );

   assign alert_status = dir_q;

   // Output only goes active one cycle after a result strobe
   assert_raise_after_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alert_n) |-> $past(conv_valid));

   // Window mode: excursion raises alert
   assert_window_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alert_en && window_mode && conv_valid && (cmp.above || cmp.below) |=> !alert_n);

   // Traditional mode: low excursion never raises the alert
   assert_trad_no_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      alert_en && !window_mode && alert_n && !(conv_valid && cmp.above) |=> alert_n);

   // Released while disabled
   assert_disabled_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !alert_en |-> alert_n && !alert_pull);

endmodule

// File: tb/thr_alert_ctrl_test.sv
module thr_alert_ctrl_test;

   typedef struct {
      bit    an;
      bit    st;
      string req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alert_en = 1'b0;
   logic        latch_en = 1'b0;
   logic        window_mode = 1'b0;
   logic [15:0] thresh_hi = 16'sd1000;
   logic [15:0] thresh_lo = -16'sd1000;
   logic        conv_valid = 1'b0;
   logic [15:0] conv_result = '0;
   logic        data_read = 1'b0;
   logic        resp_done = 1'b0;
   logic        resp_won = 1'b0;
   logic        alert_n;
   logic        alert_pull;
   logic        alert_status;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #4 clk = ~clk;  // 125 MHz

   thr_alert_ctrl uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .alert_en     (alert_en),
      .latch_en     (latch_en),
      .window_mode  (window_mode),
      .thresh_hi    (thresh_hi),
      .thresh_lo    (thresh_lo),
      .conv_valid   (conv_valid),
      .conv_result  (conv_result),
      .data_read    (data_read),
      .resp_done    (resp_done),
      .resp_won     (resp_won),
      .alert_n      (alert_n),
      .alert_pull   (alert_pull),
      .alert_status (alert_status)
   );

   task automatic check(input bit an, input bit st, input string req);
      n_cmp++;
      if (alert_n !== an || alert_pull !== ~an || alert_status !== st) begin
         n_bad++;
         $display("FAIL %s: alert_n=%b pull=%b status=%b expected alert_n=%b pull=%b status=%b",
                  req, alert_n, alert_pull, alert_status, an, ~an, st);
      end
   endtask

   // Driver: one cycle of stimulus plus its expected outcome
   task automatic step(input bit v, input int res, input bit rd, input bit rdn,
                       input bit rwn, input bit exp_alert, input bit exp_st,
                       input string req);
      exp_t e;
      @(negedge clk);
      conv_valid  = v;
      conv_result = 16'(res);
      data_read   = rd;
      resp_done   = rdn;
      resp_won    = rwn;
      e.an  = ~exp_alert;
      e.st  = exp_st;
      e.req = req;
      sb.push_back(e);
      @(posedge clk);
      @(negedge clk);
      conv_valid = 1'b0;
      data_read  = 1'b0;
      resp_done  = 1'b0;
      resp_won   = 1'b0;
   endtask

   // Monitor: compares after each edge
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.an, e.st, e.req);
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #3;
      check(1'b1, 1'b0, "R1");
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #10 check(1'b1, 1'b0, "R1");

      alert_en = 1'b1; window_mode = 1'b1; latch_en = 1'b0;
      step(1, 1001,   0, 0, 0, 1, 1, "R3");
      step(1, 1000,   0, 0, 0, 0, 1, "R2");
      step(1, -1001,  0, 0, 0, 1, 0, "R10");
      step(1, -1000,  0, 0, 0, 0, 0, "R2");
      step(1, -32768, 0, 0, 0, 1, 0, "R2");
      step(0, 0,      1, 1, 1, 1, 0, "R11");
      step(1, 0,      0, 0, 0, 0, 0, "R11");

      latch_en = 1'b1;
      step(1, 2000,  0, 0, 0, 1, 1, "R3");
      step(1, 0,     0, 0, 0, 1, 1, "R5");
      step(0, 0,     1, 0, 0, 0, 1, "R6");
      step(1, -5000, 0, 0, 0, 1, 0, "R8");
      step(0, 0,     0, 1, 0, 1, 0, "R7");
      step(0, 0,     0, 1, 1, 0, 0, "R7");
      step(1, 3000,  1, 0, 0, 1, 1, "R9");
      step(0, 0,     1, 0, 0, 0, 1, "R6");

      latch_en = 1'b0; window_mode = 1'b0;
      step(1, -5000, 0, 0, 0, 0, 1, "R4");
      step(1, 1500,  0, 0, 0, 1, 1, "R4");
      step(1, 500,   0, 0, 0, 1, 1, "R4");
      step(1, -1500, 0, 0, 0, 0, 1, "R4");

      latch_en = 1'b1; window_mode = 1'b1;
      step(1, 5000, 0, 0, 0, 1, 1, "R5");
      @(negedge clk) alert_en = 1'b0;
      #1 check(1'b1, 1'b1, "R12");
      step(1, -5000, 0, 0, 0, 0, 1, "R12");
      @(negedge clk) alert_en = 1'b1;
      step(0, 0, 0, 0, 0, 0, 1, "R12");

      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule